// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block gathers interrupt requests from fourteen on-chip sources and turns them into one 3-bit interrupt level for a processor. It keeps two 15-bit registers, an enable register and a request register. Software changes either one with a single write. Bit 15 of the written value picks the action. When bit 15 is 1, the other ones in the value are set in the chosen register. When bit 15 is 0, they are cleared.

Hardware can also raise request bits. A per-source pulse vector does this, along with two peripheral interrupt lines and a frame-wrap strobe. Bit 14 of the enable register is a master gate. The fourteen sources are grouped onto six fixed levels, and the highest level with an enabled, pending source is driven out. Both registers can be read back at any time.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A write with `wrData[15]`=1 ORs `wrData[14:0]` into the register chosen by `wrSel` (0 = enable, 1 = request). The other register is not changed.
- R2: A write with `wrData[15]`=0 clears, in the chosen register, every bit that is 1 in `wrData[14:0]`. A clear with no ones in the value changes nothing.
- R3: `irqLevel` is 0 unless enable bit 14 is 1 and (enable[13:0] AND request[13:0]) is non-zero. Request bit 14 is never a source.
- R4: The source bit positions map to levels as follows:
  - bit 13 gives level 6;
  - bits 11 and 12 give level 5;
  - bits 7 to 10 give level 4;
  - bits 4 to 6 give level 3;
  - bit 3 gives level 2;
  - bits 0 to 2 give level 1.
- R5: When several enabled sources are pending, the highest of their levels is output.
- R6: `extPortIrq` sets request bit 3, `extHighIrq` sets request bit 13, and `frameWrap` sets request bit 5.
- R7: A 1 on `srcPulse[i]` sets request bit i. This holds even when a software clear of that bit arrives in the same cycle.
- R8: `enableRd` and `requestRd` return the stored 15 bits in [14:0], and bit 15 always reads as 0.
- R9: Registers change on the clock edge at which the write or pulse is sampled. `irqLevel` follows one clock after that.
- R10: After reset both registers are 0 and `irqLevel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 enable, 1 request |
| wrData | input | 16 | Write value; bit 15 selects set or clear |
| srcPulse | input | 14 | Per-source hardware request pulses |
| extPortIrq | input | 1 | Peripheral line that raises request bit 3 |
| extHighIrq | input | 1 | Peripheral line that raises request bit 13 |
| frameWrap | input | 1 | Raster wrap strobe that raises request bit 5 |
| enableRd | output | 16 | Enable register read-back |
| requestRd | output | 16 | Request register read-back |
| irqLevel | output | 3 | Registered processor interrupt level |

## Verification
The bench builds the block with its package defaults: a 16-bit write word, 15 stored bits and 14 sources. With these defaults every level group and the master gate can be reached, and so can the unused bit 15. Level one is raised first, and then each higher group is added on top, so that each step must move the level upward. After that, clears walk the level back down. Corner cases follow these steps:
- a clear that collides with a hardware pulse on the same bit;
- request bit 14 set on its own;
- an all-ones enable write;
- an empty clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W  = 16;
  localparam int REG_W   = DATA_W - 1;
  localparam int SRC_W   = 14;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = 6;

  localparam int MASTER_BIT  = 14;
  localparam int PORT_BIT    = 3;
  localparam int FRAME_BIT   = 5;
  localparam int EXT_BIT     = 13;
  localparam int SETCLR_BIT  = DATA_W - 1;

  // Source masks per level, index 0 = level 1 ... index 5 = level 6
  localparam logic [SRC_W-1:0] LVL_MASK [NUM_LVL] = '{
    14'b00_0000_0000_0111,  // level 1: bits 0..2
    14'b00_0000_0000_1000,  // level 2: bit 3
    14'b00_0000_0111_0000,  // level 3: bits 4..6
    14'b00_0111_1000_0000,  // level 4: bits 7..10
    14'b01_1000_0000_0000,  // level 5: bits 11..12
    14'b10_0000_0000_0000   // level 6: bit 13
  };

  typedef struct packed {
    logic             setEn;
    logic             clrEn;
    logic             setReq;
    logic             clrReq;
    logic [REG_W-1:0] bits;
  } irqStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  output irqStrobe_t        strobe
);
  logic isSet;

  always_comb begin
    isSet         = wrData[SETCLR_BIT];
    strobe.bits   = wrData[REG_W-1:0];
    strobe.setEn  = wrEn && !wrSel &&  isSet;
    strobe.clrEn  = wrEn && !wrSel && !isSet;
    strobe.setReq = wrEn &&  wrSel &&  isSet;
    strobe.clrReq = wrEn &&  wrSel && !isSet;
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  irqStrobe_t       strobe,
  input  logic [SRC_W-1:0] hwSet,
  output logic [REG_W-1:0] enQ,
  output logic [REG_W-1:0] reqQ
);
  localparam int PAD_W = REG_W - SRC_W;

  logic [REG_W-1:0] enNext;
  logic [REG_W-1:0] reqNext;

  always_comb begin
    enNext = enQ;
    if (strobe.setEn) enNext = enNext | strobe.bits;
    if (strobe.clrEn) enNext = enNext & ~strobe.bits;
    reqNext = reqQ;
    if (strobe.setReq) reqNext = reqNext | strobe.bits;
    if (strobe.clrReq) reqNext = reqNext & ~strobe.bits;
    // hardware sets are applied last so they win over a same-cycle clear
    reqNext = reqNext | {{PAD_W{1'b0}}, hwSet};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ  <= '0;
      reqQ <= '0;
    end else begin
      enQ  <= enNext;
      reqQ <= reqNext;
    end
  end

  // R1: without an enable write the enable register holds
  p_en_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.setEn || strobe.clrEn) |=> $stable(enQ));

  // R2: a request clear with no hardware set empties the named bits
  p_req_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrReq && hwSet == '0) |=> ((reqQ & $past(strobe.bits)) == '0));

  // R7: a hardware pulse always leaves its bit set
  p_hw_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((reqQ[SRC_W-1:0] & $past(hwSet)) == $past(hwSet)));
endmodule

// File: rtl/irqc_level.sv
module irqc_level
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] enQ,
  input  logic [REG_W-1:0] reqQ,
  output logic [LVL_W-1:0] levelQ
);
  logic [SRC_W-1:0]   active;
  logic [NUM_LVL-1:0] groupHit;
  logic [LVL_W-1:0]   levelNext;

  assign active = enQ[MASTER_BIT] ? (enQ[SRC_W-1:0] & reqQ[SRC_W-1:0]) : '0;

  for (genvar g = 0; g < NUM_LVL; g++) begin : gGroup
    assign groupHit[g] = |(active & LVL_MASK[g]);
  end

  always_comb begin
    levelNext = '0;
    for (int g = 0; g < NUM_LVL; g++) begin
      if (groupHit[g]) levelNext = LVL_W'(g + 1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelQ <= '0;
    else       levelQ <= levelNext;
  end

  // R3: master gate off means no level
  p_master_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enQ[MASTER_BIT]) |-> (levelQ == '0));

  // R5: the top source dominates everything else
  p_top_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(enQ[MASTER_BIT] && enQ[EXT_BIT] && reqQ[EXT_BIT]) |-> (levelQ == LVL_W'(NUM_LVL)));

  // R4: the level never leaves the defined range
  p_level_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    levelQ <= LVL_W'(NUM_LVL));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SRC_W-1:0]  srcPulse,
  input  logic              extPortIrq,
  input  logic              extHighIrq,
  input  logic              frameWrap,
  output logic [DATA_W-1:0] enableRd,
  output logic [DATA_W-1:0] requestRd,
  output logic [LVL_W-1:0]  irqLevel
);
  irqStrobe_t       strobe;
  logic [SRC_W-1:0] hwSet;
  logic [REG_W-1:0] enQ;
  logic [REG_W-1:0] reqQ;

  always_comb begin
    hwSet            = srcPulse;
    hwSet[PORT_BIT]  = srcPulse[PORT_BIT]  | extPortIrq;
    hwSet[EXT_BIT]   = srcPulse[EXT_BIT]   | extHighIrq;
    hwSet[FRAME_BIT] = srcPulse[FRAME_BIT] | frameWrap;
  end

  irqc_ctrl uCtrl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .strobe (strobe)
  );

  irqc_regs uRegs (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .hwSet  (hwSet),
    .enQ    (enQ),
    .reqQ   (reqQ)
  );

  irqc_level uLevel (
    .clk    (clk),
    .rstN   (rstN),
    .enQ    (enQ),
    .reqQ   (reqQ),
    .levelQ (irqLevel)
  );

  assign enableRd  = {1'b0, enQ};
  assign requestRd = {1'b0, reqQ};

  // R6: peripheral line raises its request bit on the next edge
  p_ext_line_r6: assert property (@(posedge clk) disable iff (!rstN)
    extHighIrq |=> requestRd[EXT_BIT]);

  // R8: unused top bit always reads zero
  p_top_bit_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enableRd[DATA_W-1] && !requestRd[DATA_W-1]);
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic [13:0] srcPulse = '0;
  logic        extPortIrq = 1'b0;
  logic        extHighIrq = 1'b0;
  logic        frameWrap = 1'b0;
  logic [15:0] enableRd;
  logic [15:0] requestRd;
  logic [2:0]  irqLevel;

  always #5 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .srcPulse(srcPulse), .extPortIrq(extPortIrq), .extHighIrq(extHighIrq),
    .frameWrap(frameWrap), .enableRd(enableRd), .requestRd(requestRd),
    .irqLevel(irqLevel)
  );

  typedef struct {
    logic [15:0] en;
    logic [15:0] req;
    logic [2:0]  lvl;
    string       tag;
  } expItem_t;

  expItem_t    scoreQ[$];
  int          compared = 0;
  int          mismatched = 0;
  logic [14:0] enM = '0;
  logic [14:0] reqM = '0;
  logic [2:0]  lvlM = '0;
  bit          done = 0;

  function automatic logic [2:0] levelOf(logic [14:0] e, logic [14:0] r);
    logic [13:0] a;
    if (!e[14]) return 3'd0;
    a = e[13:0] & r[13:0];
    if (a[13])              return 3'd6;
    if (|a[12:11])          return 3'd5;
    if (|a[10:7])           return 3'd4;
    if (|a[6:4])            return 3'd3;
    if (a[3])               return 3'd2;
    if (|a[2:0])            return 3'd1;
    return 3'd0;
  endfunction

  function automatic void pushItem(logic [2:0] l, string tag);
    expItem_t it;
    it.en = {1'b0, enM};
    it.req = {1'b0, reqM};
    it.lvl = l;
    it.tag = tag;
    scoreQ.push_back(it);
  endfunction

  // Driver: applies one step and pushes the expected state after each of two edges
  task automatic step(input bit we, input bit sel, input logic [15:0] d,
                      input logic [13:0] pulse, input bit ep, input bit eh,
                      input bit fw, input string tag);
    logic [2:0] oldLvl;
    @(negedge clk);
    wrEn = we; wrSel = sel; wrData = d; srcPulse = pulse;
    extPortIrq = ep; extHighIrq = eh; frameWrap = fw;
    oldLvl = lvlM;
    if (we) begin
      if (!sel) enM  = d[15] ? (enM  | d[14:0]) : (enM  & ~d[14:0]);
      else      reqM = d[15] ? (reqM | d[14:0]) : (reqM & ~d[14:0]);
    end
    reqM = reqM | {1'b0, pulse};
    if (ep) reqM[3]  = 1'b1;
    if (eh) reqM[13] = 1'b1;
    if (fw) reqM[5]  = 1'b1;
    lvlM = levelOf(enM, reqM);
    @(negedge clk);
    wrEn = 0; wrData = '0; srcPulse = '0;
    extPortIrq = 0; extHighIrq = 0; frameWrap = 0;
    pushItem(oldLvl, {"R9 regs-first ", tag});
    @(negedge clk);
    pushItem(lvlM, tag);
  endtask

  // Monitor: compares queued expectations away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (scoreQ.size() > 0) begin
        expItem_t it;
        it = scoreQ.pop_front();
        compared++;
        if (enableRd !== it.en || requestRd !== it.req || irqLevel !== it.lvl) begin
          mismatched++;
          $display("FAIL %s: en=%h req=%h lvl=%0d expected en=%h req=%h lvl=%0d",
                   it.tag, enableRd, requestRd, irqLevel, it.en, it.req, it.lvl);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    pushItem(3'd0, "R10 reset state");
    step(1, 0, 16'hC004, '0, 0, 0, 0, "R1 set enable master+bit2");
    step(1, 1, 16'h8004, '0, 0, 0, 0, "R4 software source level 1");
    step(1, 0, 16'h8028, '0, 1, 0, 0, "R6 port line sets bit3 level 2");
    step(0, 0, 16'h0000, '0, 0, 0, 1, "R6 frame wrap sets bit5 level 3");
    step(1, 0, 16'h8100, 14'h0100, 0, 0, 0, "R7 audio pulse level 4");
    step(1, 0, 16'h8800, 14'h0800, 0, 0, 0, "R5 serial rx level 5");
    step(1, 0, 16'hA000, '0, 0, 1, 0, "R6 R5 high line level 6");
    step(1, 1, 16'h2000, '0, 0, 0, 0, "R2 clear bit13 back to 5");
    step(1, 0, 16'h4000, '0, 0, 0, 0, "R3 master off level 0");
    step(1, 0, 16'hC000, '0, 0, 0, 0, "R3 master on level 5");
    step(1, 1, 16'h0800, 14'h0800, 0, 0, 0, "R7 pulse beats same-cycle clear");
    step(1, 1, 16'h7FFF, '0, 0, 0, 0, "R2 clear all requests");
    step(1, 1, 16'hC000, '0, 0, 0, 0, "R3 request bit14 not a source");
    step(1, 0, 16'hFFFF, '0, 0, 0, 0, "R8 all-ones enable bit15 reads 0");
    step(1, 1, 16'h0000, '0, 0, 0, 0, "R2 empty clear no change");
    step(1, 1, 16'h8001, '0, 0, 0, 0, "R1 R4 bit0 level 1 enable untouched");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule